// File: doc/BRIEF.md
# UART Hardware Flow Controller

This block performs automatic hardware flow control for a single UART channel. It sits between the receive FIFO, the transmit shifter and the two modem-control pins. On the receive side it watches the FIFO fill level and drives an active-low "go" output to the peer. The output uses hysteresis: it is withdrawn at a stop level and restored only once the host has drained the FIFO to a lower resume level. It also raises a receive interrupt when the fill level reaches a programmable trigger level, and that trigger is independent of the hysteresis levels.

On the transmit side the peer's active-low "go" input passes through a synchronizer. It gates the load strobe of the transmit shifter. The decision is taken only at the moment the shifter could accept a new character, so a character already being shifted always completes, stop bit included. The FIFO, the baud generator, the shifters and the host bus are outside this block. They appear only as a fill-level input and a pending/ready/start handshake.

Both directions can be switched to manual operation. In manual operation the output follows a software bit, or the peer input is disregarded.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is held, and in the cycles after reset until the synchronizer has seen the peer input, `local_go_n` is 1, `rx_irq` is 0 and, with automatic input gating on, `tx_start` is 0.
- R2: In automatic output mode, a fill level at or above `cfg_stop_lvl` drives `local_go_n` to 1 one clock later, also when the FIFO is full (level 64).
- R3: With `cfg_resume_lvl < cfg_stop_lvl`, `local_go_n` stays 1 while the level lies strictly between the two levels. It returns to 0 one clock after the level is at or below `cfg_resume_lvl`, and stays 0 while the level rises again below the stop level.
- R4: With `cfg_resume_lvl >= cfg_stop_lvl` (invalid pair), `local_go_n` is withdrawn at the stop level and restored only one clock after the level reaches 0.
- R5: With `cfg_auto_out` = 0, `local_go_n` is the inverse of `cfg_manual_go` one clock later, whatever the fill level.
- R6: `rx_irq` is 1 one clock after the level is at or above `cfg_irq_lvl`, and 0 one clock after it drops below, independent of the stop and resume levels.
- R7: A change on `peer_go_n` affects `tx_start` exactly SYNC_STAGES (default 2) clocks later, never earlier.
- R8: `tx_start` is 1 only when `tx_pending` and `tx_ready` are both 1 and the synchronized peer input is 0 (or gating is off). A deassertion seen while `tx_ready` is 0 therefore holds back only the next character.
- R9: With `cfg_auto_in` = 0, `peer_go_n` has no effect on `tx_start`.
- R10: After reset `local_go_n` stays 1 until automatic output mode is enabled with the level below `cfg_stop_lvl`, and then drops one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W (7) | Receive FIFO fill level, 0 to FIFO_DEPTH |
| cfg_stop_lvl | input | LVL_W | Level at which the peer is told to stop |
| cfg_resume_lvl | input | LVL_W | Level at or below which the peer may resume |
| cfg_irq_lvl | input | LVL_W | Receive interrupt trigger level |
| cfg_auto_out | input | 1 | 1 = automatic output flow control |
| cfg_manual_go | input | 1 | Manual output value, 1 = tell peer to send |
| cfg_auto_in | input | 1 | 1 = gate transmit starts with the peer input |
| peer_go_n | input | 1 | Asynchronous active-low go from the peer |
| tx_pending | input | 1 | Transmit FIFO holds a character |
| tx_ready | input | 1 | Shifter can load a new character (previous stop bit done) |
| tx_start | output | 1 | Load strobe for the transmit shifter |
| local_go_n | output | 1 | Active-low go to the peer |
| rx_irq | output | 1 | Receive-data interrupt |

## Verification
The properties assume that `rx_level` never exceeds FIFO_DEPTH and that the configuration inputs are steady for at least the cycle in which they act. They also assume that `peer_go_n` is the only input that may change without regard to the clock. The stimulus changes every synchronous input one time unit after a rising edge and keeps every level within 0 to 64. It changes a threshold only on a cycle where no hysteresis transition is being checked, so each expected value follows from the requirement text alone.

// File: rtl/flow_pkg.sv
package flow_pkg;

   // Pin meaning shared by both directions: low lets the peer send.
   typedef enum logic {
      PIN_GO   = 1'b0,
      PIN_STOP = 1'b1
   } pin_e;

   function automatic int unsigned lvl_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("flow_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/flow_hyst.sv
module flow_hyst
   import flow_pkg::*;
#(
   parameter int unsigned LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] stop_lvl,
   input  logic [LVL_W-1:0] resume_lvl,
   input  logic             auto_en,
   input  logic             manual_go,
   output logic             go_n
);

   logic susp_q, susp_d;
   logic pair_ok, reach_stop, may_resume;
   pin_e pin_d;
   logic pin_q;

   assign pair_ok    = (resume_lvl < stop_lvl);
   assign reach_stop = (level >= stop_lvl);
   // Invalid pair falls back to resuming only on an empty FIFO.
   assign may_resume = pair_ok ? (level <= resume_lvl) : (level == '0);

   always_comb begin
      susp_d = susp_q;
      if (reach_stop) begin
         susp_d = 1'b1;
      end else if (may_resume) begin
         susp_d = 1'b0;
      end
   end

   always_comb begin
      if (auto_en) begin
         pin_d = susp_d ? PIN_STOP : PIN_GO;
      end else begin
         pin_d = manual_go ? PIN_GO : PIN_STOP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_q <= 1'b0;
         pin_q  <= PIN_STOP;
      end else begin
         susp_q <= susp_d;
         pin_q  <= pin_d;
      end
   end

   assign go_n = pin_q;

endmodule

// File: rtl/flow_rx_trig.sv
module flow_rx_trig #(
   parameter int unsigned LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] trig_lvl,
   output logic             irq
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= (level >= trig_lvl);
      end
   end

   assign irq = irq_q;

endmodule

// File: rtl/flow_tx_gate.sv
module flow_tx_gate
   import flow_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic peer_go_n,
   input  logic auto_en,
   input  logic pending,
   input  logic ready,
   output logic start
);

   logic peer_sync;
   logic blocked;

   flow_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (PIN_STOP)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (peer_go_n),
      .q     (peer_sync)
   );

   assign blocked = auto_en && (peer_sync == PIN_STOP);
   // Only the load point is gated; a running character is never cut.
   assign start   = pending && ready && !blocked;

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
   parameter int unsigned  FIFO_DEPTH  = 64,
   parameter int unsigned  SYNC_STAGES = 2,
   localparam int unsigned LVL_W       = flow_pkg::lvl_width(FIFO_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] cfg_stop_lvl,
   input  logic [LVL_W-1:0] cfg_resume_lvl,
   input  logic [LVL_W-1:0] cfg_irq_lvl,
   input  logic             cfg_auto_out,
   input  logic             cfg_manual_go,
   input  logic             cfg_auto_in,
   input  logic             peer_go_n,
   input  logic             tx_pending,
   input  logic             tx_ready,
   output logic             tx_start,
   output logic             local_go_n,
   output logic             rx_irq
);

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("uart_flow_ctrl: FIFO_DEPTH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_flow_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   flow_hyst #(
      .LVL_W (LVL_W)
   ) i_hyst (
      .clk        (clk),
      .rst_n      (rst_n),
      .level      (rx_level),
      .stop_lvl   (cfg_stop_lvl),
      .resume_lvl (cfg_resume_lvl),
      .auto_en    (cfg_auto_out),
      .manual_go  (cfg_manual_go),
      .go_n       (local_go_n)
   );

   flow_rx_trig #(
      .LVL_W (LVL_W)
   ) i_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (rx_level),
      .trig_lvl (cfg_irq_lvl),
      .irq      (rx_irq)
   );

   flow_tx_gate #(
      .SYNC_STAGES (SYNC_STAGES)
   ) i_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .peer_go_n (peer_go_n),
      .auto_en   (cfg_auto_in),
      .pending   (tx_pending),
      .ready     (tx_ready),
      .start     (tx_start)
   );

endmodule

// File: rtl/flow_ctrl_checker.sv
module flow_ctrl_checker #(
   parameter int unsigned LVL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] rx_level,
   input logic [LVL_W-1:0] cfg_stop_lvl,
   input logic [LVL_W-1:0] cfg_resume_lvl,
   input logic [LVL_W-1:0] cfg_irq_lvl,
   input logic             cfg_auto_out,
   input logic             cfg_manual_go,
   input logic             cfg_auto_in,
   input logic             tx_pending,
   input logic             tx_ready,
   input logic             tx_start,
   input logic             local_go_n,
   input logic             rx_irq
);

   // R2: reaching the stop level withdraws the go output next cycle
   a_r2_stop_at_level: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_out && rx_level >= cfg_stop_lvl) |=> local_go_n);

   // R3: inside the hysteresis band a withdrawn output stays withdrawn
   a_r3_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_out && $past(cfg_auto_out) && local_go_n &&
       cfg_resume_lvl < cfg_stop_lvl &&
       rx_level > cfg_resume_lvl && rx_level < cfg_stop_lvl) |=> local_go_n);

   // R4: invalid pair only resumes on an empty FIFO
   a_r4_invalid_waits_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto_out && $past(cfg_auto_out) && local_go_n &&
       cfg_resume_lvl >= cfg_stop_lvl && rx_level != '0) |=> local_go_n);

   // R5: manual mode mirrors the software bit
   a_r5_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_auto_out |=> (local_go_n == !$past(cfg_manual_go)));

   // R6: interrupt tracks the trigger comparison with one clock of delay
   a_r6_irq_track: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_irq == ($past(rx_level) >= $past(cfg_irq_lvl))));

   // R8: a load strobe needs a waiting character and an idle shifter
   a_r8_start_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> (tx_pending && tx_ready));

   // R9: without input gating the peer pin cannot block a load
   a_r9_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_auto_in && tx_pending && tx_ready) |-> tx_start);

endmodule

bind uart_flow_ctrl flow_ctrl_checker #(
   .LVL_W (LVL_W)
) i_flow_ctrl_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .rx_level       (rx_level),
   .cfg_stop_lvl   (cfg_stop_lvl),
   .cfg_resume_lvl (cfg_resume_lvl),
   .cfg_irq_lvl    (cfg_irq_lvl),
   .cfg_auto_out   (cfg_auto_out),
   .cfg_manual_go  (cfg_manual_go),
   .cfg_auto_in    (cfg_auto_in),
   .tx_pending     (tx_pending),
   .tx_ready       (tx_ready),
   .tx_start       (tx_start),
   .local_go_n     (local_go_n),
   .rx_irq         (rx_irq)
);

// File: tb/test_uart_flow_ctrl.sv
`timescale 1ns/1ps
module test_uart_flow_ctrl;

   localparam int LW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] rx_level = '0;
   logic [LW-1:0] cfg_stop_lvl = 7'd48;
   logic [LW-1:0] cfg_resume_lvl = 7'd16;
   logic [LW-1:0] cfg_irq_lvl = 7'd32;
   logic          cfg_auto_out = 1'b0;
   logic          cfg_manual_go = 1'b0;
   logic          cfg_auto_in = 1'b1;
   logic          peer_go_n = 1'b0;
   logic          tx_pending = 1'b1;
   logic          tx_ready = 1'b1;
   logic          tx_start, local_go_n, rx_irq;

   int cyc = 0;
   int checks = 0;
   int errors = 0;

   // scoreboard: parallel queues of expected items
   int    due_q[$];
   int    sel_q[$];
   logic  val_q[$];
   string req_q[$];

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   uart_flow_ctrl i_uart_flow_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .rx_level       (rx_level),
      .cfg_stop_lvl   (cfg_stop_lvl),
      .cfg_resume_lvl (cfg_resume_lvl),
      .cfg_irq_lvl    (cfg_irq_lvl),
      .cfg_auto_out   (cfg_auto_out),
      .cfg_manual_go  (cfg_manual_go),
      .cfg_auto_in    (cfg_auto_in),
      .peer_go_n      (peer_go_n),
      .tx_pending     (tx_pending),
      .tx_ready       (tx_ready),
      .tx_start       (tx_start),
      .local_go_n     (local_go_n),
      .rx_irq         (rx_irq)
   );

   function automatic string sel_name(input int s);
      case (s)
         0: return "local_go_n";
         1: return "rx_irq";
         default: return "tx_start";
      endcase
   endfunction

   function automatic logic sel_val(input int s);
      case (s)
         0: return local_go_n;
         1: return rx_irq;
         default: return tx_start;
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // driver side: schedule an expected value dly cycles from now
   task automatic expect_at(input int dly, input int sel, input logic val, input string req);
      due_q.push_back(cyc + dly);
      sel_q.push_back(sel);
      val_q.push_back(val);
      req_q.push_back(req);
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // monitor: pop and compare items that fall due in this cycle
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = due_q.size() - 1; i >= 0; i--) begin
            if (due_q[i] == cyc) begin
               check(req_q[i], sel_name(sel_q[i]), sel_val(sel_q[i]), val_q[i]);
               due_q.delete(i);
               sel_q.delete(i);
               val_q.delete(i);
               req_q.delete(i);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL watchdog (R1..) actual=hung expected=finished");
      errors++;
      checks++;
      finish_run();
   end

   task automatic lvl(input int v, input int exp_go_n, input string req);
      rx_level = 7'(v);
      if (exp_go_n >= 0) expect_at(1, 0, exp_go_n[0], req);
      step(2);
   endtask

   initial begin
      // R1: outputs while reset is held
      repeat (3) @(negedge clk);
      check("R1", "local_go_n in reset", local_go_n, 1'b1);
      check("R1", "rx_irq in reset", rx_irq, 1'b0);
      check("R1", "tx_start in reset", tx_start, 1'b0);
      step(1);
      rst_n = 1'b1;
      expect_at(0, 2, 1'b0, "R1");
      expect_at(1, 2, 1'b0, "R7");
      expect_at(2, 2, 1'b1, "R7");
      expect_at(1, 0, 1'b1, "R10");
      step(3);

      // R10: automatic mode enabled below the stop level
      cfg_auto_out = 1'b1;
      lvl(10, 0, "R10");
      // R2 / R3 hysteresis walk with stop 48, resume 16
      lvl(50, 1, "R2");
      lvl(20, 1, "R3");
      lvl(16, 0, "R3");
      lvl(30, 0, "R3");
      lvl(48, 1, "R2");
      lvl(64, 1, "R2");
      lvl(17, 1, "R3");
      lvl(0, 0, "R3");

      // R4: invalid pair, resume above stop
      cfg_stop_lvl = 7'd40;
      cfg_resume_lvl = 7'd48;
      step(1);
      lvl(40, 1, "R4");
      lvl(1, 1, "R4");
      lvl(0, 0, "R4");
      // R4: equal pair
      cfg_resume_lvl = 7'd40;
      step(1);
      lvl(45, 1, "R4");
      lvl(40, 1, "R4");
      lvl(5, 1, "R4");
      lvl(0, 0, "R4");
      cfg_stop_lvl = 7'd48;
      cfg_resume_lvl = 7'd16;
      step(1);

      // R5: manual output ignores the level
      cfg_auto_out = 1'b0;
      cfg_manual_go = 1'b1;
      lvl(64, 0, "R5");
      lvl(50, 0, "R5");
      cfg_manual_go = 1'b0;
      lvl(0, 1, "R5");

      // R6: interrupt trigger, independent of stop/resume
      cfg_irq_lvl = 7'd32;
      rx_level = 7'd31; expect_at(1, 1, 1'b0, "R6"); step(2);
      rx_level = 7'd32; expect_at(1, 1, 1'b1, "R6"); step(2);
      rx_level = 7'd64; expect_at(1, 1, 1'b1, "R6"); step(2);
      rx_level = 7'd31; expect_at(1, 1, 1'b0, "R6"); step(2);
      cfg_irq_lvl = 7'd10;
      rx_level = 7'd10; expect_at(1, 1, 1'b1, "R6"); step(2);
      rx_level = 7'd9;  expect_at(1, 1, 1'b0, "R6"); step(2);

      // R7: peer withdraws go; two clocks of synchronizer delay
      peer_go_n = 1'b1;
      expect_at(0, 2, 1'b1, "R7");
      expect_at(1, 2, 1'b1, "R7");
      expect_at(2, 2, 1'b0, "R7");
      step(3);
      // R8: shifter busy blocks a start even after go returns
      tx_ready = 1'b0;
      expect_at(0, 2, 1'b0, "R8");
      peer_go_n = 1'b0;
      expect_at(2, 2, 1'b0, "R8");
      step(3);
      tx_ready = 1'b1;
      expect_at(0, 2, 1'b1, "R8");
      step(1);
      tx_pending = 1'b0;
      expect_at(0, 2, 1'b0, "R8");
      step(1);
      tx_pending = 1'b1;
      // R8: stop arrives mid-character; next load is held back
      tx_ready = 1'b0;
      peer_go_n = 1'b1;
      step(3);
      tx_ready = 1'b1;
      expect_at(0, 2, 1'b0, "R8");
      step(1);
      peer_go_n = 1'b0;
      expect_at(1, 2, 1'b0, "R7");
      expect_at(2, 2, 1'b1, "R7");
      step(3);

      // R9: gating disabled, peer pin ignored
      cfg_auto_in = 1'b0;
      peer_go_n = 1'b1;
      expect_at(0, 2, 1'b1, "R9");
      expect_at(2, 2, 1'b1, "R9");
      expect_at(3, 2, 1'b1, "R9");
      step(5);

      check("R1", "scoreboard drained", (due_q.size() == 0), 1'b1);
      finish_run();
   end

endmodule